// File: doc/BRIEF.md
# Five-Level Bridge Dwell-Time Modulator

This block drives a single-phase bridge made of two three-level clamped legs, whose terminal voltage can take five values: full negative, half negative, zero, half positive and full positive dc-link voltage. Once per carrier period it takes a signed fixed-point terminal-voltage reference and the unsigned dc-link voltage, in the same units. From these it picks the voltage section that holds the reference and the two neighbouring levels that bound it. It then splits the carrier period between those two levels so that the period's average equals the reference.

An internal counter of `PERIOD_CLKS` clocks sets the carrier period. The inputs are captured at each period boundary. The on-times are worked out during the following period and applied in the period after that. Within an applied period the block first outputs the lower-magnitude level, then the higher-magnitude level for the rest of the period. `PERIOD_CLKS` must exceed the divider length `CNT_W + DC_W + 1` by at least two clocks.

Top module: `fivelevel_dwell_gen`

## Requirements
- R1: `periodStart` is high for exactly one clock in every `PERIOD_CLKS` clocks. It is high in the first clock after reset is released.
- R2: During reset and through the first two carrier periods after it, `levelCode` is 0 and `sectionId` is 1.
- R3: Let a = |ref| and h = floor(dc/2). If a > h the reference is in an outer section, otherwise in an inner one. `sectionId` is 0 for ref >= 0 outer, 1 for ref >= 0 inner, 2 for ref < 0 inner and 3 for ref < 0 outer.
- R4: `levelCode` is a 3-bit two's-complement value, -2 to +2, in units of half the dc-link voltage. Each section pairs a small level with a large level: section 0 uses +1 and +2, section 1 uses 0 and +1, section 2 uses 0 and -1, section 3 uses -1 and -2.
- R5: In each applied period, `levelCode` holds the small level for the first T1 clocks, counted from the clock where `periodStart` is high. It holds the large level for the remaining `PERIOD_CLKS` - T1 clocks.
- R6: The span is dc - h in an outer section and h in an inner one. The residual is dc - min(a, dc) in an outer section and h - a in an inner one. T1 = floor((PERIOD_CLKS * residual + floor(span/2)) / span).
- R7: A reference whose magnitude exceeds dc saturates to the full level for the whole period (T1 = 0). If the span is zero, T1 is 0 in an outer section and `PERIOD_CLKS` in an inner one.
- R8: The inputs present in the last clock of a carrier period are the ones sampled. Their result appears in the period that starts one full period later. Input changes at any other time have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refVolt | input | REF_W | Signed terminal-voltage reference |
| dcLink | input | DC_W | Unsigned dc-link voltage, same units as the reference |
| levelCode | output | 3 | Signed requested terminal level, -2 to +2 |
| sectionId | output | 2 | Section of the period now applied |
| periodStart | output | 1 | High in the first clock of each carrier period |

## Verification
The hardest case to reach from the ports is an input change in the middle of a period, because it must not disturb a dwell split that was computed one period earlier. The bench provokes this in every test vector. Halfway through each observed period it drives scrambled values onto both inputs, then restores the next real vector before the period boundary. The sweep also lands the reference on the half and full dc-link boundaries, beyond full scale, and on tiny dc-link values where the span drops to zero.

// File: rtl/dwell_pkg.sv
package dwell_pkg;

  typedef enum logic [1:0] {
    SEC_I   = 2'd0,
    SEC_II  = 2'd1,
    SEC_III = 2'd2,
    SEC_IV  = 2'd3
  } section_e;

  typedef struct packed {
    logic wrap;
    logic divInit;
    logic divStep;
  } ctrl_strobe_t;

  function automatic logic signed [2:0] smallLevel(section_e sec);
    case (sec)
      SEC_I:   smallLevel = 3'sd1;
      SEC_II:  smallLevel = 3'sd0;
      SEC_III: smallLevel = 3'sd0;
      default: smallLevel = -3'sd1;
    endcase
  endfunction

  function automatic logic signed [2:0] largeLevel(section_e sec);
    case (sec)
      SEC_I:   largeLevel = 3'sd2;
      SEC_II:  largeLevel = 3'sd1;
      SEC_III: largeLevel = -3'sd1;
      default: largeLevel = -3'sd2;
    endcase
  endfunction

endpackage

// File: rtl/dwell_ctrl.sv
module dwell_ctrl
  import dwell_pkg::*;
#(
  parameter int PERIOD_CLKS = 3333,
  parameter int CNT_W       = 12,
  parameter int DIV_STEPS   = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  output ctrl_strobe_t strobes,
  output logic         periodStart
);

  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PERIOD_CLKS - 1);
  localparam logic [CNT_W-1:0] STEP_END = CNT_W'(DIV_STEPS);

  logic [CNT_W-1:0] carrierCnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      carrierCnt <= '0;
    end else if (carrierCnt == LAST_CNT) begin
      carrierCnt <= '0;
    end else begin
      carrierCnt <= carrierCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.wrap    = (carrierCnt == LAST_CNT);
    strobes.divInit = (carrierCnt == '0);
    strobes.divStep = (carrierCnt != '0) && (carrierCnt <= STEP_END);
    periodStart     = (carrierCnt == '0);
  end

endmodule

// File: rtl/dwell_datapath.sv
module dwell_datapath
  import dwell_pkg::*;
#(
  parameter int REF_W       = 16,
  parameter int DC_W        = 15,
  parameter int PERIOD_CLKS = 3333,
  parameter int CNT_W       = 12,
  parameter int NUM_W       = 28
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  ctrl_strobe_t            strobes,
  input  logic signed [REF_W-1:0] refVolt,
  input  logic        [DC_W-1:0]  dcLink,
  output logic signed [2:0]       levelCode,
  output logic        [1:0]       sectionId
);

  localparam int MAG_W = ((REF_W > DC_W) ? REF_W : DC_W) + 1;
  localparam logic [NUM_W-1:0] PERIOD_NUM = NUM_W'(PERIOD_CLKS);
  localparam logic [CNT_W-1:0] PERIOD_CNT = CNT_W'(PERIOD_CLKS);

  // Inputs held for the whole period
  logic signed [REF_W-1:0] refHold;
  logic        [DC_W-1:0]  dcHold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      refHold <= '0;
      dcHold  <= '0;
    end else if (strobes.wrap) begin
      refHold <= refVolt;
      dcHold  <= dcLink;
    end
  end

  // Section decode and volt-second terms from the held inputs
  logic                    refNeg;
  logic signed [REF_W:0]   refWide;
  logic signed [REF_W:0]   refAbs;
  logic        [MAG_W-1:0] refMag;
  logic        [MAG_W-1:0] dcExt;
  logic        [MAG_W-1:0] halfExt;
  logic        [MAG_W-1:0] magSat;
  logic                    isOuter;
  logic        [DC_W-1:0]  residual;
  logic        [DC_W-1:0]  spanVal;
  logic        [NUM_W-1:0] numerator;
  section_e                newSection;

  always_comb begin
    refNeg   = refHold[REF_W-1];
    refWide  = REF_W'(refHold) == '0 ? '0 : {refHold[REF_W-1], refHold};
    refAbs   = refNeg ? -refWide : refWide;
    refMag   = MAG_W'($unsigned(refAbs));
    dcExt    = MAG_W'(dcHold);
    halfExt  = dcExt >> 1;
    isOuter  = (refMag > halfExt);
    magSat   = (refMag > dcExt) ? dcExt : refMag;
    if (isOuter) begin
      residual = DC_W'(dcExt - magSat);
      spanVal  = DC_W'(dcExt - halfExt);
    end else begin
      residual = DC_W'(halfExt - refMag);
      spanVal  = DC_W'(halfExt);
    end
    numerator = PERIOD_NUM * NUM_W'(residual) + NUM_W'(spanVal >> 1);
    case ({isOuter, refNeg})
      2'b10:   newSection = SEC_I;
      2'b00:   newSection = SEC_II;
      2'b01:   newSection = SEC_III;
      default: newSection = SEC_IV;
    endcase
  end

  // Serial restoring divider, one quotient bit per step
  logic [NUM_W-1:0] divNumQ;
  logic [DC_W-1:0]  divRem;
  logic [DC_W-1:0]  divDen;
  logic [DC_W:0]    remShift;
  logic             remFits;
  section_e         pendSection;
  logic             pendSpanZero;
  logic             pendOuter;

  always_comb begin
    remShift = {divRem, divNumQ[NUM_W-1]};
    remFits  = (remShift >= {1'b0, divDen});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      divNumQ      <= '0;
      divRem       <= '0;
      divDen       <= '0;
      pendSection  <= SEC_II;
      pendSpanZero <= 1'b1;
      pendOuter    <= 1'b0;
    end else if (strobes.divInit) begin
      divNumQ      <= numerator;
      divRem       <= '0;
      divDen       <= spanVal;
      pendSection  <= newSection;
      pendSpanZero <= (spanVal == '0);
      pendOuter    <= isOuter;
    end else if (strobes.divStep) begin
      divNumQ <= {divNumQ[NUM_W-2:0], remFits};
      if (remFits) begin
        divRem <= DC_W'(remShift - {1'b0, divDen});
      end else begin
        divRem <= remShift[DC_W-1:0];
      end
    end
  end

  // Applied period: section and remaining small-level clocks
  logic [CNT_W-1:0] nextT1;
  section_e         actSection;
  logic [CNT_W-1:0] smallLeft;

  always_comb begin
    if (pendSpanZero) begin
      nextT1 = pendOuter ? '0 : PERIOD_CNT;
    end else if (divNumQ > PERIOD_NUM) begin
      nextT1 = PERIOD_CNT;
    end else begin
      nextT1 = CNT_W'(divNumQ);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      actSection <= SEC_II;
      smallLeft  <= PERIOD_CNT;
    end else if (strobes.wrap) begin
      actSection <= pendSection;
      smallLeft  <= nextT1;
    end else if (smallLeft != '0) begin
      smallLeft <= smallLeft - 1'b1;
    end
  end

  always_comb begin
    levelCode = (smallLeft != '0) ? smallLevel(actSection) : largeLevel(actSection);
    sectionId = actSection;
  end

endmodule

// File: rtl/fivelevel_dwell_gen.sv
module fivelevel_dwell_gen
  import dwell_pkg::*;
#(
  parameter int REF_W       = 16,
  parameter int DC_W        = 15,
  parameter int PERIOD_CLKS = 3333
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [REF_W-1:0] refVolt,
  input  logic        [DC_W-1:0]  dcLink,
  output logic signed [2:0]       levelCode,
  output logic        [1:0]       sectionId,
  output logic                    periodStart
);

  localparam int CNT_W = $clog2(PERIOD_CLKS + 1);
  localparam int NUM_W = CNT_W + DC_W + 1;

  ctrl_strobe_t strobes;

  dwell_ctrl #(
    .PERIOD_CLKS(PERIOD_CLKS),
    .CNT_W      (CNT_W),
    .DIV_STEPS  (NUM_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .periodStart(periodStart)
  );

  dwell_datapath #(
    .REF_W      (REF_W),
    .DC_W       (DC_W),
    .PERIOD_CLKS(PERIOD_CLKS),
    .CNT_W      (CNT_W),
    .NUM_W      (NUM_W)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .refVolt  (refVolt),
    .dcLink   (dcLink),
    .levelCode(levelCode),
    .sectionId(sectionId)
  );

endmodule

// File: rtl/fivelevel_dwell_gen_chk.sv
module fivelevel_dwell_gen_chk #(
  parameter int PERIOD_CLKS = 3333,
  parameter int CNT_W       = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic signed [2:0] levelCode,
  input logic        [1:0] sectionId,
  input logic              periodStart
);

  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PERIOD_CLKS - 1);

  logic [CNT_W-1:0] sinceStart;
  logic             seenStart;
  logic [1:0]       switchCnt;
  logic signed [2:0] prevLevel;
  logic             levelMoved;
  logic             pairOk;

  always_comb begin
    levelMoved = !periodStart && (levelCode != prevLevel);
    case (sectionId)
      2'd0:    pairOk = (levelCode == 3'sd1)  || (levelCode == 3'sd2);
      2'd1:    pairOk = (levelCode == 3'sd0)  || (levelCode == 3'sd1);
      2'd2:    pairOk = (levelCode == 3'sd0)  || (levelCode == -3'sd1);
      default: pairOk = (levelCode == -3'sd1) || (levelCode == -3'sd2);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sinceStart <= '0;
      seenStart  <= 1'b0;
      switchCnt  <= '0;
      prevLevel  <= '0;
    end else begin
      prevLevel <= levelCode;
      if (periodStart) begin
        sinceStart <= '0;
        seenStart  <= 1'b1;
        switchCnt  <= '0;
      end else begin
        if (sinceStart != '1) sinceStart <= sinceStart + 1'b1;
        if (levelMoved && switchCnt != 2'd3) switchCnt <= switchCnt + 1'b1;
      end
    end
  end

  AST_START_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (periodStart && seenStart) |-> (sinceStart == LAST_CNT)); // R1
  AST_START_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    (seenStart && !periodStart && sinceStart == LAST_CNT) |=> periodStart); // R1
  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (levelCode >= -3'sd2) && (levelCode <= 3'sd2)); // R4
  AST_SECTION_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    pairOk); // R4
  AST_SECTION_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (seenStart && !periodStart) |-> $stable(sectionId)); // R8
  AST_SINGLE_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    (seenStart && levelMoved) |-> (switchCnt == 2'd0)); // R5
  AST_SWITCH_OUTWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (seenStart && levelMoved) |->
      ((sectionId < 2'd2) ? (levelCode == prevLevel + 3'sd1)
                          : (levelCode == prevLevel - 3'sd1))); // R5

endmodule

bind fivelevel_dwell_gen fivelevel_dwell_gen_chk #(
  .PERIOD_CLKS(PERIOD_CLKS),
  .CNT_W      (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .levelCode  (levelCode),
  .sectionId  (sectionId),
  .periodStart(periodStart)
);

// File: tb/fivelevel_dwell_gen_tb.sv
module fivelevel_dwell_gen_tb;

  localparam int P  = 40;
  localparam int RW = 12;
  localparam int DW = 10;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic signed [RW-1:0] refVolt = '0;
  logic        [DW-1:0] dcLink = '0;
  logic signed [2:0]    levelCode;
  logic        [1:0]    sectionId;
  logic                 periodStart;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fivelevel_dwell_gen #(.REF_W(RW), .DC_W(DW), .PERIOD_CLKS(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .refVolt(refVolt), .dcLink(dcLink),
    .levelCode(levelCode), .sectionId(sectionId), .periodStart(periodStart)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic model(input int r, input int d, output int t1, output int sec,
                       output int lvSmall, output int lvLarge);
    int a, h, sat, resid, span;
    bit outer;
    a = (r < 0) ? -r : r;
    h = d / 2;
    outer = (a > h);
    if (outer) begin
      sat = (a > d) ? d : a;
      resid = d - sat;
      span = d - h;
    end else begin
      resid = h - a;
      span = h;
    end
    if (span == 0) t1 = outer ? 0 : P;
    else t1 = (P * resid + span / 2) / span;
    if (t1 > P) t1 = P;
    sec = outer ? ((r < 0) ? 3 : 0) : ((r < 0) ? 2 : 1);
    case (sec)
      0: begin lvSmall = 1;  lvLarge = 2;  end
      1: begin lvSmall = 0;  lvLarge = 1;  end
      2: begin lvSmall = 0;  lvLarge = -1; end
      default: begin lvSmall = -1; lvLarge = -2; end
    endcase
  endtask

  task automatic waitStart();
    do @(negedge clk); while (!periodStart);
  endtask

  task automatic runVec(input int r, input int d);
    int t1, sec, lvS, lvL, expLv, badAct, badExp, badStart, badSec;
    bit lvOk, secOk, startOk;
    string tag;
    refVolt = RW'(r);
    dcLink  = DW'(d);
    model(r, d, t1, sec, lvS, lvL);
    lvOk = 1'b1; secOk = 1'b1; startOk = 1'b1;
    badAct = 0; badExp = 0; badStart = 0; badSec = int'(sectionId);
    waitStart();  // period in which the sampled inputs are processed (R8)
    waitStart();  // period in which they are applied
    for (int i = 0; i < P; i++) begin
      if (i > 0) @(negedge clk);
      expLv = (i < t1) ? lvS : lvL;
      if (lvOk && int'(levelCode) != expLv) begin
        lvOk = 1'b0; badAct = int'(levelCode); badExp = expLv;
      end
      if (secOk && int'(sectionId) != sec) begin
        secOk = 1'b0; badSec = int'(sectionId);
      end
      if (startOk && periodStart != (i == 0)) begin
        startOk = 1'b0; badStart = i;
      end
      if (i == P / 2) begin
        refVolt = ~RW'(r);       // mid-period disturbance, must be ignored (R8)
        dcLink  = DW'(d) ^ DW'(10'h155);
      end
    end
    refVolt = RW'(r);
    dcLink  = DW'(d);
    tag = (((r < 0) ? -r : r) > d || (d / 2) == 0) ? "R7 R5 R4 R8" : "R6 R5 R4 R8";
    check(lvOk, tag, badAct, badExp);
    check(secOk, "R3", badSec, sec);
    check(startOk, "R1", badStart, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL R1 watchdog act=%0d exp=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int bad;
    repeat (3) @(negedge clk);
    check(levelCode == 3'sd0, "R2", int'(levelCode), 0);
    check(sectionId == 2'd1, "R2", int'(sectionId), 1);
    rst_n = 1'b1;
    #1;
    check(periodStart == 1'b1, "R1", int'(periodStart), 1);
    bad = 0;
    for (int i = 1; i < P; i++) begin
      @(negedge clk);
      if (levelCode != 3'sd0 || sectionId != 2'd1) bad++;
    end
    check(bad == 0, "R2", bad, 0);

    for (int r = -4; r <= 4; r++)
      for (int d = 0; d <= 3; d++) runVec(r, d);
    for (int r = -45; r <= 45; r++) runVec(r, 37);
    for (int r = -700; r <= 700; r += 7) runVec(r, 600);
    foreach (bnd[k]) runVec(bnd[k], 600);
    foreach (big[k]) runVec(big[k], 1023);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  int bnd[13] = '{299, 300, 301, -299, -300, -301, 600, 601, -600, -601, 0, 2047, -2048};
  int big[9]  = '{-2048, -1024, -1023, -512, -511, 511, 512, 1023, 2047};

endmodule